// File: doc/BRIEF.md
# Serial-Programmed Dual Converter Register Controller

This block is the digital control logic of a two-channel, 10-bit serially programmed converter. A three-wire port (an active-low frame select that also acts as the load strobe, a serial clock and a serial data line) carries a 16-bit command word. The word holds a 4-bit command code, then a 10-bit code value, then two pad bits. All three serial pins are sampled by a faster system clock through two-flop synchronizers. Edges of the serial clock and of the frame select are then found by comparing each synchronized level with its value one cycle earlier.

Each channel holds two registers. The staging register takes new codes. The output register drives the converter code. Because of this split, channels can be staged one at a time and then updated together. When the frame select rises, the command code is decoded and applied in one system-clock cycle. That cycle can load one or both staging registers, copy both staging registers into the output registers, and move the power state between awake and asleep. While asleep, the high-impedance flag is raised. Every register keeps its value while asleep, and the staging registers can still be written.

The frame state machine has three states. `FR_IDLE` means the frame select is high. `FR_SHIFT` means a frame is open. `FR_EXEC` is a one-cycle apply state. Its transitions are:
- `FR_IDLE` to `FR_SHIFT` when the frame select goes low.
- `FR_SHIFT` to `FR_EXEC` when the frame select goes high.
- `FR_EXEC` to `FR_IDLE` if the frame select is still high.
- `FR_EXEC` to `FR_SHIFT` if the frame select has gone low again.

The power state machine has two states, `PWR_AWAKE` and `PWR_ASLEEP`. It leaves `PWR_AWAKE` when a sleep command executes. It leaves `PWR_ASLEEP` when any command that wakes the part executes.

Top module: `sdac_dual_ctrl`

## Requirements
- R1: While `rst` is high, and after it is released, both output codes are 0 and `hiz_o` is 0 (awake). Both staging registers are also 0.
- R2: While the frame select is low, each serial-clock rising edge shifts one data bit into a 16-bit word. The command code comes first and the code value second, each MSB first, followed by two ignored bits. If more than 16 bits arrive in a frame, the last 16 are used.
- R3: A command takes effect only when the frame select rises. Output codes do not change while a frame is still open. Serial-clock edges while the frame select is high change nothing.
- R4: Code 0001 loads staging register A and code 0010 loads staging register B. Neither code changes the output codes or `hiz_o`.
- R5: Code 1000 copies both staging registers into the output registers and sets the awake state (`hiz_o` = 0).
- R6: Codes 1001 and 1010 load staging register A or B, respectively, with the new value. Both output registers are then updated from the staging registers, and the part wakes.
- R7: Code 1101 wakes the part and leaves all registers unchanged. Code 1110 sets `hiz_o` = 1, ignores the code value and keeps every register.
- R8: Code 1111 writes the same value to both staging registers and both output registers, and wakes the part.
- R9: Code 0000 and the unused codes 0011, 0100, 0101, 0110, 0111, 1011 and 1100 change nothing.
- R10: Staging registers written while asleep hold their new values. A wake by 1101 restores the previous output codes.
- R11: An output code changes only in the cycle after a command is applied, and the apply state lasts exactly one system-clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_ld_i | input | 1 | Frame select and load strobe; low opens a frame, the rising edge applies the command |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| sdata_i | input | 1 | Serial data |
| dac_a_o | output | 10 | Output register code, channel A |
| dac_b_o | output | 10 | Output register code, channel B |
| hiz_o | output | 1 | High when asleep; the converter outputs are to be high impedance |

## Verification
The assertions assume that the serial pins are slow compared with the system clock, so that every synchronized level lasts at least two cycles. They also assume that data is stable around each serial-clock rise and that the frame select rises only after the word is complete. The stimulus holds each serial phase for four system clocks. It changes data only while the serial clock is low and waits after each frame closes. Toggles of the serial clock with the frame select high and over-long frames are applied in directed cases. Random commands are drawn from all sixteen codes, with random code values and random pad bits.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int CODE_W = 10;
    localparam int CTRL_W = 4;
    localparam int PAD_W  = 2;
    localparam int WORD_W = CTRL_W + CODE_W + PAD_W;
    localparam int NUM_CH = 2;

    localparam logic [CTRL_W-1:0] OP_NOP      = 4'b0000;
    localparam logic [CTRL_W-1:0] OP_STAGE_A  = 4'b0001;
    localparam logic [CTRL_W-1:0] OP_STAGE_B  = 4'b0010;
    localparam logic [CTRL_W-1:0] OP_COMMIT   = 4'b1000;
    localparam logic [CTRL_W-1:0] OP_STAGE_A_COMMIT = 4'b1001;
    localparam logic [CTRL_W-1:0] OP_STAGE_B_COMMIT = 4'b1010;
    localparam logic [CTRL_W-1:0] OP_WAKE     = 4'b1101;
    localparam logic [CTRL_W-1:0] OP_SLEEP    = 4'b1110;
    localparam logic [CTRL_W-1:0] OP_BOTH_ALL = 4'b1111;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SHIFT = 2'd1,
        FR_EXEC  = 2'd2
    } frame_state_t;

    typedef enum logic {
        PWR_AWAKE  = 1'b0,
        PWR_ASLEEP = 1'b1
    } pwr_state_t;

    typedef struct packed {
        logic [NUM_CH-1:0] load;
        logic              update;
        logic              wake;
        logic              sleep;
    } op_t;

    function automatic op_t decode_op(input logic [CTRL_W-1:0] code);
        op_t op;
        op = '0;
        unique case (code)
            OP_STAGE_A:        op.load = 2'b01;
            OP_STAGE_B:        op.load = 2'b10;
            OP_COMMIT:         begin op.update = 1'b1; op.wake = 1'b1; end
            OP_STAGE_A_COMMIT: begin op.load = 2'b01; op.update = 1'b1; op.wake = 1'b1; end
            OP_STAGE_B_COMMIT: begin op.load = 2'b10; op.update = 1'b1; op.wake = 1'b1; end
            OP_WAKE:           op.wake = 1'b1;
            OP_SLEEP:          op.sleep = 1'b1;
            OP_BOTH_ALL:       begin op.load = 2'b11; op.update = 1'b1; op.wake = 1'b1; end
            default:           op = '0;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/sdac_frame.sv
module sdac_frame
    import sdac_pkg::*;
#(
    parameter int CW = CTRL_W,
    parameter int DW = CODE_W,
    parameter int PW = PAD_W,
    localparam int WW = CW + DW + PW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_s,
    input  logic          sclk_s,
    input  logic          sdata_s,
    output logic          exec_o,
    output logic [CW-1:0] cmd_o,
    output logic [DW-1:0] code_o
);

    frame_state_t state_q;
    frame_state_t state_d;
    logic         sclk_d;
    logic         sclk_rise;
    logic [WW-1:0] shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE:  if (!cs_s) state_d = FR_SHIFT;
            FR_SHIFT: if (cs_s)  state_d = FR_EXEC;
            FR_EXEC:  state_d = cs_s ? FR_IDLE : FR_SHIFT;
            default:  state_d = FR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        exec_o = (state_q == FR_EXEC);
        cmd_o  = shreg_q[WW-1 -: CW];
        code_o = shreg_q[PW +: DW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
        end else if (!cs_s && sclk_rise) begin
            shreg_q <= {shreg_q[WW-2:0], sdata_s};
        end
    end

endmodule

// File: rtl/sdac_power.sv
module sdac_power
    import sdac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go_i,
    input  logic wake_i,
    input  logic sleep_i,
    output logic hiz_o
);

    pwr_state_t state_q;
    pwr_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PWR_AWAKE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_AWAKE:  if (go_i && sleep_i) state_d = PWR_ASLEEP;
            PWR_ASLEEP: if (go_i && wake_i)  state_d = PWR_AWAKE;
            default:    state_d = PWR_AWAKE;
        endcase
    end

    always_comb begin
        hiz_o = (state_q == PWR_ASLEEP);
    end

endmodule

// File: rtl/sdac_chan.sv
module sdac_chan #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic          update_i,
    input  logic [DW-1:0] code_i,
    output logic [DW-1:0] out_o
);

    logic [DW-1:0] stage_q;
    logic [DW-1:0] stage_d;
    logic [DW-1:0] out_q;

    assign stage_d = load_i ? code_i : stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            out_q   <= '0;
        end else begin
            stage_q <= stage_d;
            if (update_i) begin
                out_q <= stage_d;
            end
        end
    end

    assign out_o = out_q;

endmodule

// File: rtl/sdac_dual_ctrl.sv
module sdac_dual_ctrl
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_ld_i,
    input  logic              sclk_i,
    input  logic              sdata_i,
    output logic [CODE_W-1:0] dac_a_o,
    output logic [CODE_W-1:0] dac_b_o,
    output logic              hiz_o
);

    logic [2:0]        pins_s;
    logic              cmd_exec;
    logic [CTRL_W-1:0] cmd;
    logic [CODE_W-1:0] code;
    op_t               op;
    logic [CODE_W-1:0] chan_out [NUM_CH];

    sdac_sync #(
        .W       (3),
        .RST_VAL (3'b100)
    ) i_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({cs_ld_i, sclk_i, sdata_i}),
        .sync_o  (pins_s)
    );

    sdac_frame #(
        .CW (CTRL_W),
        .DW (CODE_W),
        .PW (PAD_W)
    ) i_frame (
        .clk     (clk),
        .rst     (rst),
        .cs_s    (pins_s[2]),
        .sclk_s  (pins_s[1]),
        .sdata_s (pins_s[0]),
        .exec_o  (cmd_exec),
        .cmd_o   (cmd),
        .code_o  (code)
    );

    assign op = decode_op(cmd);

    sdac_power i_power (
        .clk     (clk),
        .rst     (rst),
        .go_i    (cmd_exec),
        .wake_i  (op.wake),
        .sleep_i (op.sleep),
        .hiz_o   (hiz_o)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        sdac_chan #(
            .DW (CODE_W)
        ) i_chan (
            .clk      (clk),
            .rst      (rst),
            .load_i   (cmd_exec & op.load[ch]),
            .update_i (cmd_exec & op.update),
            .code_i   (code),
            .out_o    (chan_out[ch])
        );
    end

    assign dac_a_o = chan_out[0];
    assign dac_b_o = chan_out[1];

endmodule

// File: rtl/sdac_dual_ctrl_chk.sv
module sdac_dual_ctrl_chk
    import sdac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_exec,
    input logic [CTRL_W-1:0] cmd,
    input logic [CODE_W-1:0] dac_a,
    input logic [CODE_W-1:0] dac_b,
    input logic              hiz
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (dac_a == '0 && dac_b == '0 && !hiz)); // R1

    AST_EXEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cmd_exec |=> !cmd_exec); // R11

    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmd_exec |=> ($stable(dac_a) && $stable(dac_b))); // R3

    AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (cmd_exec && (cmd == 4'b0001 || cmd == 4'b0010))
        |=> ($stable(dac_a) && $stable(dac_b) && $stable(hiz))); // R4

    AST_COMMIT_WAKE: assert property (@(posedge clk) disable iff (rst)
        (cmd_exec && (cmd == 4'b1000 || cmd == 4'b1001 || cmd == 4'b1010)) |=> !hiz); // R5

    AST_SLEEP_SET: assert property (@(posedge clk) disable iff (rst)
        (cmd_exec && cmd == 4'b1110)
        |=> (hiz && $stable(dac_a) && $stable(dac_b))); // R7

    AST_WAKE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (cmd_exec && cmd == 4'b1101)
        |=> (!hiz && $stable(dac_a) && $stable(dac_b))); // R7

    AST_BOTH_SAME: assert property (@(posedge clk) disable iff (rst)
        (cmd_exec && cmd == 4'b1111) |=> (dac_a == dac_b && !hiz)); // R8

    AST_RESERVED_NOP: assert property (@(posedge clk) disable iff (rst)
        (cmd_exec && (cmd == 4'b0000 || cmd == 4'b0011 || cmd == 4'b0100 ||
                      cmd == 4'b0101 || cmd == 4'b0110 || cmd == 4'b0111 ||
                      cmd == 4'b1011 || cmd == 4'b1100))
        |=> ($stable(dac_a) && $stable(dac_b) && $stable(hiz))); // R9

endmodule

bind sdac_dual_ctrl sdac_dual_ctrl_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_exec (cmd_exec),
    .cmd      (cmd),
    .dac_a    (dac_a_o),
    .dac_b    (dac_b_o),
    .hiz      (hiz_o)
);

// File: tb/test_sdac_dual_ctrl.sv
module test_sdac_dual_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_ld = 1'b1;
    logic       sclk = 1'b0;
    logic       sdata = 1'b0;
    logic [9:0] dac_a;
    logic [9:0] dac_b;
    logic       hiz;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    logic [9:0] m_stage [2];
    logic [9:0] m_out   [2];
    bit         m_sleep;

    always #2.5 clk = ~clk;

    sdac_dual_ctrl i_sdac_dual_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cs_ld_i (cs_ld),
        .sclk_i  (sclk),
        .sdata_i (sdata),
        .dac_a_o (dac_a),
        .dac_b_o (dac_b),
        .hiz_o   (hiz)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag);
        n_chk++;
        if (dac_a !== m_out[0] || dac_b !== m_out[1] || hiz !== m_sleep) begin
            n_bad++;
            $display("FAIL %s: got a=%h b=%h hiz=%b, expected a=%h b=%h hiz=%b",
                     tag, dac_a, dac_b, hiz, m_out[0], m_out[1], m_sleep);
        end
    endtask

    task automatic model_apply(input logic [3:0] c, input logic [9:0] v);
        case (c)
            4'b0001: m_stage[0] = v;
            4'b0010: m_stage[1] = v;
            4'b1000: begin m_out[0] = m_stage[0]; m_out[1] = m_stage[1]; m_sleep = 0; end
            4'b1001: begin m_stage[0] = v; m_out[0] = v; m_out[1] = m_stage[1]; m_sleep = 0; end
            4'b1010: begin m_stage[1] = v; m_out[0] = m_stage[0]; m_out[1] = v; m_sleep = 0; end
            4'b1101: m_sleep = 0;
            4'b1110: m_sleep = 1;
            4'b1111: begin m_stage[0] = v; m_stage[1] = v; m_out[0] = v; m_out[1] = v; m_sleep = 0; end
            default: ;
        endcase
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        cs_ld = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            sdata = v[i];
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
        wait_clk(4);
    endtask

    task automatic end_frame();
        cs_ld = 1'b1;
        wait_clk(12);
    endtask

    task automatic send(input logic [3:0] c, input logic [9:0] v, input logic [1:0] pad);
        shift_bits({16'h0, c, v, pad}, 16);
        end_frame();
        model_apply(c, v);
    endtask

    task automatic cmd_chk(input string tag, input logic [3:0] c, input logic [9:0] v);
        send(c, v, 2'b11);
        check(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R3 watchdog: got no completion, expected completion within 200000 cycles");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_stage[0] = '0; m_stage[1] = '0;
        m_out[0] = '0;   m_out[1] = '0;
        m_sleep = 0;
        void'($urandom(32'd1661));
        wait_clk(6);
        check("R1 during reset");
        rst = 1'b0;
        wait_clk(6);
        check("R1 after reset");

        // staging only, then commit
        cmd_chk("R4 stage A", 4'b0001, 10'h155);
        cmd_chk("R4 stage B", 4'b0010, 10'h2AA);
        cmd_chk("R5 commit both", 4'b1000, 10'h000);
        cmd_chk("R6 stage A and commit", 4'b1001, 10'h201);
        cmd_chk("R6 stage B and commit", 4'b1010, 10'h3FF);

        // sleep, stage while asleep, wake
        cmd_chk("R7 sleep keeps codes", 4'b1110, 10'h123);
        cmd_chk("R10 stage A while asleep", 4'b0001, 10'h0AB);
        cmd_chk("R10 stage B while asleep", 4'b0010, 10'h0CD);
        cmd_chk("R7 wake restores codes", 4'b1101, 10'h3C3);
        cmd_chk("R10 staged values kept", 4'b1000, 10'h000);

        // reserved and no-op codes
        cmd_chk("R9 code 0000", 4'b0000, 10'h3FF);
        cmd_chk("R9 code 0011", 4'b0011, 10'h111);
        cmd_chk("R9 code 0100", 4'b0100, 10'h222);
        cmd_chk("R9 code 0101", 4'b0101, 10'h333);
        cmd_chk("R9 code 0110", 4'b0110, 10'h044);
        cmd_chk("R9 code 0111", 4'b0111, 10'h155);
        cmd_chk("R9 code 1011", 4'b1011, 10'h266);
        cmd_chk("R9 code 1100", 4'b1100, 10'h377);

        cmd_chk("R8 same code to both", 4'b1111, 10'h200);

        // nothing before the frame closes
        shift_bits({16'h0, 4'b1001, 10'h3C3, 2'b01}, 16);
        check("R3 no change while frame open");
        end_frame();
        model_apply(4'b1001, 10'h3C3);
        check("R3 applied at frame close");

        // serial clock toggles with frame select high
        for (int i = 0; i < 6; i++) begin
            sdata = i[0];
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
        wait_clk(12);
        check("R3 serial clock ignored while deselected");

        // over-long frame: last 16 bits used
        shift_bits({12'h0, 4'b1110, 4'b1010, 10'h0F0, 2'b10}, 20);
        end_frame();
        model_apply(4'b1010, 10'h0F0);
        check("R2 last sixteen bits of long frame");

        cmd_chk("R2 bit order asymmetric code", 4'b1001, 10'h001);

        // random commands
        for (int k = 0; k < 300; k++) begin
            logic [3:0] c;
            logic [9:0] v;
            logic [1:0] p;
            c = 4'($urandom_range(0, 15));
            v = 10'($urandom);
            p = 2'($urandom);
            send(c, v, p);
            check($sformatf("R11 random cmd %b code %h", c, v));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule